// File: doc/BRIEF.md
# I2C Register Target with Word-Length-Aware Auto-Increment

This block is an I2C target that lets an external controller read and write a small internal register space. The space is split into address ranges, and each range holds words of a fixed byte count between one and five. After the device address byte, the controller sends a 16-bit subaddress as two bytes, high byte first. Data bytes then move into or out of the addressed word, most significant byte first. In a burst, the subaddress advances only after a complete word has been transferred. The byte count of that word comes from the range the subaddress falls in.

SCL and SDA are brought into the system clock domain through two-flop synchronizers, and edges are detected there. Start and stop conditions are decoded from those edges. SDA is driven open-drain through a single pull-low output. A write word is stored only after its final byte has been acknowledged, so a transfer cut short leaves the register space untouched. At the top of the map, reads keep returning the highest register. Writes that run past the top are refused with a no-acknowledge.

Top module: `i2c_varword_slave`

## Requirements
- R1: A stop (SDA rising while SCL is high) returns the target to idle and releases SDA. A start or repeated start (SDA falling while SCL is high) at any point abandons the current transfer and begins a new address byte.
- R2: The first byte after a start carries the 7-bit device address (parameter DEV_ADDR, default 7'h34) in bits 7:1 and the direction in bit 0, where 0 is a write and 1 is a read. An address that does not match gets no acknowledge, and the target ignores the bus until the next start or stop.
- R3: The target acknowledges a matched address byte, both subaddress bytes and each accepted write-data byte by holding SDA low through the ninth SCL clock.
- R4: The subaddress is sent high byte first, then low byte. The high byte is always acknowledged. If the full 16-bit value is above the top subaddress (10), the low byte gets no acknowledge and the target goes idle.
- R5: The map has four ranges. Subaddresses 0-3 hold 1-byte words, 4-6 hold 2-byte words, 7-8 hold 4-byte words and 9-10 hold 5-byte words. Words are transferred most significant byte first.
- R6: During a burst, the subaddress advances by one only after the last byte of the current word. The byte count is taken from the range of the current subaddress.
- R7: A write word is stored only when the ninth clock of its final byte ends. A word that is still incomplete when a start or stop arrives is discarded.
- R8: A read is a subaddress write, then a repeated start, then the address byte with direction 1. The target then drives data bytes. It continues while the controller acknowledges, and stops driving after a no-acknowledge.
- R9: A read that runs past subaddress 10 keeps returning the word at subaddress 10 from its first byte.
- R10: A write data byte that arrives after the word at subaddress 10 has been stored is discarded and gets no acknowledge, and the target goes idle. No other register changes.
- R11: SDA is pulled low only in acknowledge or data-out bit slots. The pull is asserted only while SCL is low, and SDA is released after reset.
- R12: All registers read as zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample SCL and SDA |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain); low releases the line |

## Verification
The bench builds the block with its defaults: device address 7'h34, two synchronizer stages and the 11-entry map of four ranges. Because the map is this small, the bench can start a burst write and a burst read at every one of the 11 subaddresses. Those bursts cross every range boundary and run off the top of the map in both directions. The bursts use lengths that leave words partial. Separate transfers cover bad subaddresses, a mismatched device address and transfers aborted mid-byte.

// File: rtl/i2cvw_pkg.sv
package i2cvw_pkg;

  localparam int NUM_RANGES = 4;
  localparam int MAX_BYTES  = 5;
  localparam int WORD_W     = 8 * MAX_BYTES;

  // word byte count and entry count of each range, ranges placed back to back from 0
  localparam int RANGE_BYTES [NUM_RANGES] = '{1, 2, 4, 5};
  localparam int RANGE_LEN   [NUM_RANGES] = '{4, 3, 2, 2};

  function automatic int count_entries();
    int n;
    n = 0;
    for (int r = 0; r < NUM_RANGES; r++) n += RANGE_LEN[r];
    return n;
  endfunction

  localparam int          NUM_ENTRIES = count_entries();
  localparam int          IDX_W       = $clog2(NUM_ENTRIES);
  localparam logic [15:0] TOP_ADDR    = 16'(NUM_ENTRIES - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_HOLD
  } state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_SUBH,
    K_SUBL,
    K_WDATA
  } kind_e;

  function automatic logic addr_ok(logic [15:0] a);
    return a <= TOP_ADDR;
  endfunction

  function automatic logic [2:0] word_bytes(logic [15:0] a);
    logic [2:0] nb;
    int         base;
    nb   = 3'd1;
    base = 0;
    for (int r = 0; r < NUM_RANGES; r++) begin
      if (int'(a) >= base && int'(a) < base + RANGE_LEN[r]) nb = 3'(RANGE_BYTES[r]);
      base += RANGE_LEN[r];
    end
    return nb;
  endfunction

endpackage

// File: rtl/i2cvw_rst_sync.sv
module i2cvw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];

endmodule

// File: rtl/i2cvw_line_sync.sv
module i2cvw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rose_o,
  output logic fell_o
);

  logic [STAGES-1:0] stg_q, stg_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      assign stg_d = line_i;
    end else begin : g_many
      assign stg_d = {stg_q[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '1;
      prev_q <= 1'b1;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rose_o  = stg_q[STAGES-1] & ~prev_q;
  assign fell_o  = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2cvw_regfile.sv
module i2cvw_regfile
  import i2cvw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [WORD_W-1:0] ent [NUM_ENTRIES];

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic [WORD_W-1:0] word_q;
      logic              hit;

      assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   word_q <= '0;
        else if (hit) word_q <= wr_data_i;
      end

      assign ent[e] = word_q;
    end
  endgenerate

  assign rd_data_o = ent[rd_idx_i];

endmodule

// File: rtl/i2cvw_ctrl.sv
module i2cvw_ctrl
  import i2cvw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              sda_pull_o
);

  state_e            state_q, state_d;
  kind_e             kind_q, kind_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [7:0]        subhi_q, subhi_d;
  logic [15:0]       ptr_q, ptr_d;
  logic [2:0]        bidx_q, bidx_d;
  logic [WORD_W-1:0] wbuf_q, wbuf_d;
  logic              commit_q, commit_d;
  logic              pull_q, pull_d;
  logic [7:0]        txsh_q, txsh_d;
  logic              mack_q, mack_d;

  logic [2:0]        wr_nb;
  logic [2:0]        rd_nb;
  logic [2:0]        rd_sel;
  logic [7:0]        rd_byte;

  // read side clamps to the top entry once the pointer has left the map
  assign rd_idx_o = IDX_W'((ptr_q > TOP_ADDR) ? TOP_ADDR : ptr_q);
  assign rd_nb    = word_bytes((ptr_q > TOP_ADDR) ? TOP_ADDR : ptr_q);
  assign wr_nb    = word_bytes(ptr_q);
  assign rd_sel   = rd_nb - 3'd1 - bidx_q;

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < MAX_BYTES; b++) begin
      if (rd_sel == 3'(b)) rd_byte = rd_data_i[8*b +: 8];
    end
  end

  assign wr_idx_o   = IDX_W'(ptr_q);
  assign wr_data_o  = wbuf_q;
  assign sda_pull_o = pull_q;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    subhi_d  = subhi_q;
    ptr_d    = ptr_q;
    bidx_d   = bidx_q;
    wbuf_d   = wbuf_q;
    commit_d = commit_q;
    pull_d   = pull_q;
    txsh_d   = txsh_q;
    mack_d   = mack_q;
    wr_en_o  = 1'b0;

    if (stop_i) begin
      state_d  = ST_IDLE;
      pull_d   = 1'b0;
      commit_d = 1'b0;
    end else if (start_i) begin
      state_d  = ST_RX;
      kind_d   = K_ADDR;
      bitcnt_d = '0;
      bidx_d   = '0;
      pull_d   = 1'b0;
      commit_d = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            shreg_d  = {shreg_q[6:0], sda_i};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall_i && bitcnt_q == 4'd8) begin
            state_d = ST_HOLD;
            case (kind_q)
              K_ADDR: begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  state_d = ST_RXACK;
                  pull_d  = 1'b1;
                  if (!shreg_q[0]) kind_d = K_SUBH;
                end
              end
              K_SUBH: begin
                subhi_d = shreg_q;
                state_d = ST_RXACK;
                pull_d  = 1'b1;
                kind_d  = K_SUBL;
              end
              K_SUBL: begin
                if (addr_ok({subhi_q, shreg_q})) begin
                  ptr_d   = {subhi_q, shreg_q};
                  bidx_d  = '0;
                  state_d = ST_RXACK;
                  pull_d  = 1'b1;
                  kind_d  = K_WDATA;
                end
              end
              default: begin
                if (addr_ok(ptr_q)) begin
                  state_d = ST_RXACK;
                  pull_d  = 1'b1;
                  if (bidx_q == 3'd0) wbuf_d = WORD_W'(shreg_q);
                  else                wbuf_d = {wbuf_q[WORD_W-9:0], shreg_q};
                  if (bidx_q == wr_nb - 3'd1) commit_d = 1'b1;
                  else                        bidx_d   = bidx_q + 3'd1;
                end
              end
            endcase
          end
        end

        ST_RXACK: begin
          if (scl_fall_i) begin
            pull_d   = 1'b0;
            bitcnt_d = '0;
            state_d  = ST_RX;
            if (commit_q) begin
              wr_en_o  = 1'b1;
              commit_d = 1'b0;
              ptr_d    = ptr_q + 16'd1;
              bidx_d   = '0;
            end
            if (kind_q == K_ADDR) begin
              state_d = ST_TX;
              txsh_d  = rd_byte;
              pull_d  = ~rd_byte[7];
            end
          end
        end

        ST_TX: begin
          if (scl_rise_i) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bitcnt_q == 4'd8) begin
              pull_d  = 1'b0;
              state_d = ST_TXACK;
              if (bidx_q == rd_nb - 3'd1) begin
                bidx_d = '0;
                if (ptr_q < TOP_ADDR) ptr_d = ptr_q + 16'd1;
              end else begin
                bidx_d = bidx_q + 3'd1;
              end
            end else begin
              txsh_d = {txsh_q[6:0], txsh_q[7]};
              pull_d = ~txsh_q[6];
            end
          end
        end

        ST_TXACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_d  = ST_TX;
              bitcnt_d = '0;
              txsh_d   = rd_byte;
              pull_d   = ~rd_byte[7];
            end else begin
              state_d = ST_HOLD;
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= K_ADDR;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      subhi_q  <= '0;
      ptr_q    <= '0;
      bidx_q   <= '0;
      wbuf_q   <= '0;
      commit_q <= 1'b0;
      pull_q   <= 1'b0;
      txsh_q   <= '0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      subhi_q  <= subhi_d;
      ptr_q    <= ptr_d;
      bidx_q   <= bidx_d;
      wbuf_q   <= wbuf_d;
      commit_q <= commit_d;
      pull_q   <= pull_d;
      txsh_q   <= txsh_d;
      mack_q   <= mack_d;
    end
  end

endmodule

// File: rtl/i2c_varword_slave.sv
module i2c_varword_slave
  import i2cvw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h34,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);

  logic              rst_n;
  logic              scl_lvl, scl_rise, scl_fall;
  logic              sda_lvl, sda_rise, sda_fall;
  logic              start_evt, stop_evt;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [WORD_W-1:0] wr_data, rd_data;

  i2cvw_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  i2cvw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (scl_i),
    .level_o (scl_lvl),
    .rose_o  (scl_rise),
    .fell_o  (scl_fall)
  );

  i2cvw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (sda_i),
    .level_o (sda_lvl),
    .rose_o  (sda_rise),
    .fell_o  (sda_fall)
  );

  assign start_evt = scl_lvl & sda_fall;
  assign stop_evt  = scl_lvl & sda_rise;

  i2cvw_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_lvl),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .sda_pull_o (sda_pull_o)
  );

  i2cvw_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

endmodule

// File: rtl/i2cvw_chk.sv
module i2cvw_chk
  import i2cvw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             scl_fall,
  input logic             sda_pull,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx
);

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_lvl)); // R11

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull); // R1

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull); // R1

  AST_COMMIT_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_ENTRIES)); // R10

  AST_COMMIT_AT_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_fall); // R7

endmodule

bind i2c_varword_slave i2cvw_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .scl_fall  (scl_fall),
  .sda_pull  (sda_pull_o),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx)
);

// File: tb/i2c_varword_slave_tb.sv
`timescale 1ns/1ps
module i2c_varword_slave_tb;

  localparam logic [6:0] DEV = 7'h34;
  localparam int Q    = 8;
  localparam int NREG = 11;
  localparam int TOP  = 10;

  logic clk;
  logic arst_n;
  logic m_scl, m_sda;
  logic sda_pull;
  logic sda_line;
  int   nvec, nfail;
  logic done;

  logic [39:0] exp_mem [NREG];

  assign sda_line = m_sda & ~sda_pull;

  i2c_varword_slave #(.DEV_ADDR(DEV)) u_dut (
    .clk        (clk),
    .arst_n     (arst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // map of R5: 0-3 one byte, 4-6 two, 7-8 four, 9-10 five
  function automatic int bw(int a);
    if (a < 4) return 1;
    if (a < 7) return 2;
    if (a < 9) return 4;
    return 5;
  endfunction

  function automatic logic [7:0] pat(int s, int k);
    return 8'((s * 29 + k * 13 + 7) ^ (k << 4));
  endfunction

  function automatic logic [7:0] word_byte(int a, int j);
    return 8'(exp_mem[a] >> (8 * (bw(a) - 1 - j)));
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q / 2);
    b = sda_line; tick(Q - Q / 2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic bit_v;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(bit_v);
    ack = ~bit_v;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    logic bit_v;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(bit_v);
      v[i] = bit_v;
    end
    send_bit(~give_ack);
  endtask

  task automatic set_sub(input logic [15:0] a, output logic a0, output logic a1, output logic a2);
    i2c_start();
    wbyte({DEV, 1'b0}, a0);
    wbyte(a[15:8], a1);
    wbyte(a[7:0], a2);
  endtask

  // burst write of n pattern bytes from subaddress s, acks compared to the model
  task automatic write_burst(input int s, input int n, input int seed);
    logic a0, a1, a2, ack;
    int   p, bi;
    logic [39:0] acc;
    logic exp_ack;
    set_sub(16'(s), a0, a1, a2);
    check("R3 address ack", 40'(a0), 40'd1);
    check("R4 subaddress acks", {38'd0, a1, a2}, 40'd3);
    p = s; bi = 0; acc = '0;
    for (int k = 0; k < n; k++) begin
      exp_ack = (p <= TOP);
      wbyte(pat(seed, k), ack);
      check("R3 R6 R10 data ack", 40'(ack), 40'(exp_ack));
      if (!exp_ack) break;
      acc = (bi == 0) ? 40'(pat(seed, k)) : {acc[31:0], pat(seed, k)};
      if (bi == bw(p) - 1) begin
        exp_mem[p] = acc;
        p++; bi = 0;
      end else begin
        bi++;
      end
    end
    i2c_stop();
  endtask

  // burst read of n bytes from subaddress s, compared to the model
  task automatic read_burst(input int s, input int n, input string tag);
    logic a0, a1, a2, ack;
    logic [7:0] v;
    int p, bi;
    set_sub(16'(s), a0, a1, a2);
    i2c_start();
    wbyte({DEV, 1'b1}, ack);
    check("R8 read address ack", 40'(ack), 40'd1);
    p = s; bi = 0;
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, v);
      check(tag, 40'(v), 40'(word_byte(p, bi)));
      if (bi == bw(p) - 1) begin
        bi = 0;
        if (p < TOP) p++;
      end else begin
        bi++;
      end
    end
    i2c_stop();
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, ack;
    nvec = 0; nfail = 0;
    m_scl = 1'b1; m_sda = 1'b1;
    arst_n = 1'b0;
    for (int i = 0; i < NREG; i++) exp_mem[i] = '0;
    tick(5);
    arst_n = 1'b1;
    tick(5);

    // R11: released after reset
    check("R11 SDA released after reset", 40'(sda_pull), 40'd0);

    // R12: all registers zero, R9 top repeat
    read_burst(0, 31, "R12 R5 reset contents");

    // R2: wrong address, both directions
    i2c_start();
    wbyte({7'h35, 1'b0}, ack);
    check("R2 mismatched write address nack", 40'(ack), 40'd0);
    i2c_stop();
    i2c_start();
    wbyte({7'h14, 1'b1}, ack);
    check("R2 mismatched read address nack", 40'(ack), 40'd0);
    i2c_stop();
    check("R1 SDA released after stop", 40'(sda_pull), 40'd0);

    // R6 R7 R8 R9 R10: burst write and read starting at every subaddress
    for (int s = 0; s < NREG; s++) begin
      write_burst(s, (s * 3) % 7 + 3, s + 1);
      read_burst(s, 12, "R6 R8 R9 burst readback");
    end

    // R4: subaddresses off the map
    set_sub(16'd11, a0, a1, a2);
    check("R4 subaddress 11 hi ack", 40'(a1), 40'd1);
    check("R4 subaddress 11 lo nack", 40'(a2), 40'd0);
    i2c_stop();
    set_sub(16'h0100, a0, a1, a2);
    check("R4 subaddress 0x0100 lo nack", 40'(a2), 40'd0);
    wbyte(8'h5A, ack);
    check("R4 bytes after bad subaddress ignored", 40'(ack), 40'd0);
    i2c_stop();

    // R1 R7: repeated start mid-word discards the partial 2-byte word at 4
    set_sub(16'd4, a0, a1, a2);
    wbyte(8'hC3, ack);
    check("R3 first byte of word ack", 40'(ack), 40'd1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_start();
    check("R1 SDA released after repeated start", 40'(sda_pull), 40'd0);
    wbyte({DEV, 1'b0}, ack);
    check("R1 new address after repeated start", 40'(ack), 40'd1);
    i2c_stop();
    read_burst(4, 2, "R7 partial word discarded");

    // R1: stop inside an address byte, then a normal transfer
    i2c_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    i2c_stop();
    check("R1 SDA released after early stop", 40'(sda_pull), 40'd0);
    write_burst(2, 1, 77);
    read_burst(2, 1, "R1 transfer after abort");

    // R10: write past the top of the map
    write_burst(9, 12, 91);
    read_burst(0, 31, "R10 R5 full map after overrun");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule